// File: doc/BRIEF.md
# Boot Clock Control

This block chooses which of two oscillator inputs drives the boot clock and holds a boot-mode flag that overrides the dividers of every managed clock path. The boot clock source comes from a software choice when a software-override bit is set. Otherwise it comes from a select input that fuse and security logic decide. A change of source passes through a gated handover. The old source is switched off while its level is low, at least one cycle passes with neither source enabled, and then the new source is switched on while its level is low.

Four counter-based dividers run on the fast reference clock `clk`. Each produces a level output and a one-cycle rising-boundary pulse. While the boot-mode flag is set, the programmed divisors are ignored and every divider runs at divide-by-one. A cold reset always sets the flag. A warm reset sets it only when the policy input asks for it. Software can set the flag at any time and clears it to leave boot mode. All pins are plain control and status pins. The block has no streaming interface, so there is no valid/ready back-pressure.

The register port is a single-cycle write strobe with a combinational read. Address 0 is the control word. Addresses 1 to 4 hold the divisors of dividers 0 to 3.

Top module: `bootclk_ctrl`

## Requirements
- R1: A write with `reg_wr` high stores its data at the next `clk` edge. `reg_rdata` shows the addressed word combinationally. Address 0 reads bit0 = software override enable, bit1 = software select, bit2 = boot-mode flag, bit3 = source select in use, and 0 in all other bits. Addresses 1..4 read the stored 8-bit divisor in bits 7:0. Unmapped addresses read 0.
- R2: The requested select is the software select when the override bit is 1, and `fuse_sel` when it is 0. Select 0 means `osc_clk` and select 1 means `intosc_clk`. `eff_sel` follows the requested select once the handover completes.
- R3: While the override bit is 0, writing the software select bit leaves `eff_sel` and `boot_clk` unaffected.
- R4: `boot_clk` equals the AND of each source with its enable, ORed together. The two enables are never on together. Switching from one source to the other leaves at least one cycle with both enables off. The old source is disabled only at an edge where its input is low, and the new source is enabled only at an edge where its input is low. `eff_sel` changes in the same cycle the new enable turns on.
- R5: After cold reset (`cold_rst_n` low, asynchronous), the boot-mode flag is 1, the override and select bits are 0, every divisor is 0, and `osc_clk` is the enabled source.
- R6: A one-cycle `warm_rst` sets the boot-mode flag when `warm_sets_boot` is 1. When `warm_sets_boot` is 0, the flag keeps its value. A warm set wins over a software clear in the same cycle.
- R7: While the boot-mode flag is set, after the next output boundary of each divider, `div_rise` is high every cycle and `div_lvl` stays high, whatever the divisors hold.
- R8: Writing address 0 with bit2 = 1 sets the boot-mode flag, and bit2 = 0 clears it. Clearing it by a write is the only way to leave boot mode.
- R9: With boot mode clear, a divider with divisor N (0 taken as 1) pulses `div_rise` once every N cycles. `div_lvl` is high for ceil(N/2) cycles starting with the pulse cycle and low for floor(N/2) cycles.
- R10: A new divisor value, or a change of the boot-mode flag, takes effect only at the edge that ends the divider's current output period, so the period in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock feeding the dividers and control logic |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| warm_sets_boot | input | 1 | Policy: a warm reset sets the boot-mode flag when 1 |
| fuse_sel | input | 1 | Fuse/security-derived boot clock select |
| osc_clk | input | 1 | Primary oscillator source (select 0) |
| intosc_clk | input | 1 | Internal oscillator divided by two (select 1) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| boot_clk | output | 1 | Gated boot clock |
| boot_mode | output | 1 | Current boot-mode flag |
| eff_sel | output | 1 | Source select currently enabled |
| div_rise | output | 4 | Per-divider output rising-boundary pulse |
| div_lvl | output | 4 | Per-divider output clock level |

## Verification
The assertions assume that both oscillator inputs change only between `clk` edges and stay at each level for at least one full `clk` cycle. This is why the low-level gating conditions can be judged at the reference edge. They also assume that `warm_rst` is a single-cycle synchronous pulse and that writes use mapped addresses when they target the control word. The stimulus toggles the oscillators on falling `clk` edges every three and five cycles. It drives every input, including the warm pulse, only at or just after a falling edge, and it sends all control writes to address 0.

// File: rtl/bootclk_pkg.sv
package bootclk_pkg;

  localparam int CTRL_ADDR  = 0;
  localparam int BIT_SW_EN  = 0;
  localparam int BIT_SW_SEL = 1;
  localparam int BIT_BOOT   = 2;
  localparam int BIT_EFF    = 3;

  typedef enum logic [1:0] {
    HO_RUN   = 2'd0,
    HO_DRAIN = 2'd1,
    HO_GAP   = 2'd2
  } handover_e;

  typedef struct packed {
    logic sw_en;
    logic sw_sel;
    logic boot_mode;
  } ctrl_t;

endpackage

// File: rtl/bootclk_regs.sv
module bootclk_regs
  import bootclk_pkg::*;
#(
  parameter int NUM_DIV = 4,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            cold_rst_n,
  input  logic                            warm_rst,
  input  logic                            warm_sets_boot,
  input  logic                            reg_wr,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  input  logic                            eff_sel,
  output ctrl_t                           ctrl,
  output logic [NUM_DIV-1:0][DIV_W-1:0]   div_val,
  output logic [DATA_W-1:0]               reg_rdata
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic ctrl_hit;
  assign ctrl_hit = reg_wr && (reg_addr == CTRL_A);

  // control word; a warm set of the flag is applied last so it wins
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      ctrl <= '{sw_en: 1'b0, sw_sel: 1'b0, boot_mode: 1'b1};
    end else begin
      if (ctrl_hit) begin
        ctrl.sw_en     <= reg_wdata[BIT_SW_EN];
        ctrl.sw_sel    <= reg_wdata[BIT_SW_SEL];
        ctrl.boot_mode <= reg_wdata[BIT_BOOT];
      end
      if (warm_rst && warm_sets_boot) begin
        ctrl.boot_mode <= 1'b1;
      end
    end
  end

  // one divisor register per divider, at consecutive addresses after control
  for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_div_reg
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(gi + 1);
    always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
        div_val[gi] <= '0;
      end else if (reg_wr && (reg_addr == MY_A)) begin
        div_val[gi] <= reg_wdata[DIV_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A) begin
      reg_rdata[BIT_SW_EN]  = ctrl.sw_en;
      reg_rdata[BIT_SW_SEL] = ctrl.sw_sel;
      reg_rdata[BIT_BOOT]   = ctrl.boot_mode;
      reg_rdata[BIT_EFF]    = eff_sel;
    end
    for (int i = 0; i < NUM_DIV; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) begin
        reg_rdata[DIV_W-1:0] = div_val[i];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:DIV_W];

endmodule

// File: rtl/bootclk_src_switch.sv
module bootclk_src_switch
  import bootclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sel,
  input  logic [1:0] src_lvl,
  output logic [1:0] src_en,
  output logic       cur_sel
);

  handover_e state;

  // drop the old gate while its source is low, idle one cycle or more,
  // then open the new gate while the new source is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= HO_RUN;
      src_en  <= 2'b01;
      cur_sel <= 1'b0;
    end else begin
      unique case (state)
        HO_RUN: begin
          if (req_sel != cur_sel) state <= HO_DRAIN;
        end
        HO_DRAIN: begin
          if (!src_lvl[cur_sel]) begin
            src_en[cur_sel] <= 1'b0;
            state           <= HO_GAP;
          end
        end
        HO_GAP: begin
          if (!src_lvl[req_sel]) begin
            src_en[req_sel] <= 1'b1;
            cur_sel         <= req_sel;
            state           <= HO_RUN;
          end
        end
        default: state <= HO_RUN;
      endcase
    end
  end

endmodule

// File: rtl/bootclk_divider.sv
module bootclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] target,
  output logic             rise,
  output logic             lvl
);

  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   high_len;
  logic             last;

  assign last     = (cnt == period - 1'b1);
  assign high_len = ({1'b0, period} + 1'b1) >> 1;
  assign rise     = (cnt == '0);
  assign lvl      = ({1'b0, cnt} < high_len);

  // the period is reloaded only as the current output period ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= DIV_W'(1);
      cnt    <= '0;
    end else if (last) begin
      cnt    <= '0;
      period <= target;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bootclk_ctrl.sv
module bootclk_ctrl
  import bootclk_pkg::*;
#(
  parameter int NUM_DIV = 4,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               cold_rst_n,
  input  logic               warm_rst,
  input  logic               warm_sets_boot,
  input  logic               fuse_sel,
  input  logic               osc_clk,
  input  logic               intosc_clk,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               boot_clk,
  output logic               boot_mode,
  output logic               eff_sel,
  output logic [NUM_DIV-1:0] div_rise,
  output logic [NUM_DIV-1:0] div_lvl
);

  ctrl_t                         ctrl;
  logic [NUM_DIV-1:0][DIV_W-1:0] div_val;
  logic [1:0]                    src_en;
  logic                          req_sel;

  bootclk_regs #(
    .NUM_DIV(NUM_DIV), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk            (clk),
    .cold_rst_n     (cold_rst_n),
    .warm_rst       (warm_rst),
    .warm_sets_boot (warm_sets_boot),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .eff_sel        (eff_sel),
    .ctrl           (ctrl),
    .div_val        (div_val),
    .reg_rdata      (reg_rdata)
  );

  assign req_sel = ctrl.sw_en ? ctrl.sw_sel : fuse_sel;

  bootclk_src_switch u_switch (
    .clk     (clk),
    .rst_n   (cold_rst_n),
    .req_sel (req_sel),
    .src_lvl ({intosc_clk, osc_clk}),
    .src_en  (src_en),
    .cur_sel (eff_sel)
  );

  assign boot_clk  = (osc_clk & src_en[0]) | (intosc_clk & src_en[1]);
  assign boot_mode = ctrl.boot_mode;

  for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_div
    logic [DIV_W-1:0] tgt;
    assign tgt = (ctrl.boot_mode || (div_val[gi] == '0)) ? DIV_W'(1) : div_val[gi];

    bootclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (cold_rst_n),
      .target (tgt),
      .rise   (div_rise[gi]),
      .lvl    (div_lvl[gi])
    );
  end

endmodule

// File: rtl/bootclk_ctrl_chk.sv
module bootclk_ctrl_chk #(
  parameter int NUM_DIV = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               cold_rst_n,
  input logic               warm_rst,
  input logic               warm_sets_boot,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               boot_mode,
  input logic [1:0]         src_en,
  input logic [NUM_DIV-1:0] div_rise,
  input logic [NUM_DIV-1:0] div_lvl
);

  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == '0);

  AST_ONE_GATE: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $onehot0(src_en)); // R4

  AST_GATE_GAP: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (($past(src_en) != 2'b00) && (src_en != 2'b00)) |-> (src_en == $past(src_en))); // R4

  AST_WARM_SET: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst && warm_sets_boot) |=> boot_mode); // R6

  AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst && !warm_sets_boot && !ctrl_wr) |=> $stable(boot_mode)); // R6

  AST_SW_FLAG: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (ctrl_wr && !warm_rst) |=> (boot_mode == $past(reg_wdata[2]))); // R8

  for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_chk
    AST_BOOT_BYPASS: assert property (@(posedge clk) disable iff (!cold_rst_n)
      ($past(boot_mode) && div_rise[gi]) |=> div_rise[gi]); // R7

    AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!cold_rst_n)
      div_rise[gi] |-> div_lvl[gi]); // R9
  end

endmodule

bind bootclk_ctrl bootclk_ctrl_chk #(
  .NUM_DIV(NUM_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk            (clk),
  .cold_rst_n     (cold_rst_n),
  .warm_rst       (warm_rst),
  .warm_sets_boot (warm_sets_boot),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .boot_mode      (boot_mode),
  .src_en         (src_en),
  .div_rise       (div_rise),
  .div_lvl        (div_lvl)
);

// File: tb/bootclk_ctrl_bench.sv
module bootclk_ctrl_bench;

  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        warm_sets_boot = 1'b0;
  logic        fuse_sel = 1'b0;
  logic        osc_clk = 1'b0;
  logic        intosc_clk = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        boot_clk, boot_mode, eff_sel;
  logic [ND-1:0] div_rise, div_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  bootclk_ctrl u_bootclk_ctrl (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst),
    .warm_sets_boot(warm_sets_boot), .fuse_sel(fuse_sel),
    .osc_clk(osc_clk), .intosc_clk(intosc_clk), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .boot_clk(boot_clk), .boot_mode(boot_mode), .eff_sel(eff_sel),
    .div_rise(div_rise), .div_lvl(div_lvl)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_act[ND];
  int m_cnt[ND];
  int m_div[ND];
  bit m_sw_en, m_sw_sel, m_boot, m_cur;
  bit [1:0] m_en;
  int m_st;

  always @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      for (int i = 0; i < ND; i++) begin m_act[i] = 1; m_cnt[i] = 0; m_div[i] = 0; end
      m_sw_en = 0; m_sw_sel = 0; m_boot = 1; m_cur = 0; m_en = 2'b01; m_st = 0;
    end else begin
      bit want;
      bit [1:0] lv;
      for (int i = 0; i < ND; i++) begin
        int tgt;
        tgt = (m_boot || m_div[i] == 0) ? 1 : m_div[i];
        if (m_cnt[i] == m_act[i] - 1) begin m_cnt[i] = 0; m_act[i] = tgt; end
        else m_cnt[i]++;
      end
      want = m_sw_en ? m_sw_sel : fuse_sel;
      lv = {intosc_clk, osc_clk};
      if (m_st == 0) begin
        if (want != m_cur) m_st = 1;
      end else if (m_st == 1) begin
        if (!lv[m_cur]) begin m_en[m_cur] = 0; m_st = 2; end
      end else begin
        if (!lv[want]) begin m_en[want] = 1; m_cur = want; m_st = 0; end
      end
      if (reg_wr && reg_addr == 0) begin
        m_sw_en = reg_wdata[0]; m_sw_sel = reg_wdata[1]; m_boot = reg_wdata[2];
      end else if (reg_wr && reg_addr >= 1 && reg_addr <= ND) begin
        m_div[reg_addr-1] = int'(reg_wdata[7:0]);
      end
      if (warm_rst && warm_sets_boot) m_boot = 1;
    end
  end

  // compare every cycle, just after the falling edge
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      longint exp_rd;
      exp_rd = 0;
      if (reg_addr == 0) exp_rd = {m_cur, m_boot, m_sw_sel, m_sw_en};
      else if (reg_addr <= ND) exp_rd = m_div[reg_addr-1];
      check("R1 rdata", reg_rdata, exp_rd);
      check("R8 boot_mode", boot_mode, m_boot);
      check("R2 eff_sel", eff_sel, m_cur);
      check("R4 boot_clk", boot_clk, (osc_clk & m_en[0]) | (intosc_clk & m_en[1]));
      for (int i = 0; i < ND; i++) begin
        check(m_act[i] == 1 && m_boot ? "R7 rise" : "R9 rise", div_rise[i], m_cnt[i] == 0);
        check(m_act[i] == 1 && m_boot ? "R7 lvl" : "R9 lvl", div_lvl[i],
              m_cnt[i] < (m_act[i] + 1) / 2);
      end
    end
  end

  // oscillator stimulus: toggles on falling edges
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (k % 3 == 0) osc_clk = ~osc_clk;
      if (k % 5 == 0) intosc_clk = ~intosc_clk;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    #2;
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge clk);
    #2;
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
      reg_addr = 3'((i % 6));
    end
  endtask

  task automatic wait_rise(input int d, output int n);
    n = 0;
    do begin @(negedge clk); #2; n++; end while (!div_rise[d]);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #2 cold_rst_n = 1;
    @(negedge clk);
    #2;
    // R5 reset state
    reg_addr = 0;
    #1;
    check("R5 boot flag", boot_mode, 1);
    check("R5 eff_sel", eff_sel, 0);
    check("R5 ctrl word", reg_rdata, 4);
    reg_addr = 1;
    #1;
    check("R5 divisor", reg_rdata, 0);
    cmp_on = 1;

    // programmed divisors ignored in boot mode (R7)
    wr(1, 5); wr(2, 4); wr(3, 8); wr(4, 7);
    idle(20);
    check("R7 bypass rise", div_rise, 4'hF);
    // leave boot mode (R8)
    wr(0, 0);
    idle(60);
    // R10: divisor change waits for the period boundary
    wait_rise(1, n);
    reg_wr = 1; reg_addr = 2; reg_wdata = 6;
    @(negedge clk); #2; reg_wr = 0;
    n = 1;
    while (!div_rise[1]) begin @(negedge clk); #2; n++; end
    check("R10 old period kept", n, 4);
    wait_rise(1, n);
    check("R10 new period", n, 6);
    // fuse-driven switch (R2)
    fuse_sel = 1;
    idle(40);
    check("R2 fuse select", eff_sel, 1);
    fuse_sel = 0;
    idle(40);
    // R3: software select ignored without override
    wr(0, 2);
    idle(40);
    check("R3 sw_sel ignored", eff_sel, 0);
    // software override
    wr(0, 3);
    idle(40);
    check("R2 sw select", eff_sel, 1);
    wr(0, 1);
    idle(30);
    // divide by zero treated as one (R9)
    wr(1, 0); wr(3, 3);
    idle(30);
    // R6 warm reset policy
    @(negedge clk); #2 warm_rst = 1; warm_sets_boot = 0;
    @(negedge clk); #2 warm_rst = 0;
    check("R6 warm keep", boot_mode, 0);
    idle(10);
    @(negedge clk); #2 warm_rst = 1; warm_sets_boot = 1;
    reg_wr = 1; reg_addr = 0; reg_wdata = 1;
    @(negedge clk); #2 warm_rst = 0; reg_wr = 0;
    check("R6 warm set wins", boot_mode, 1);
    idle(30);
    // R8 software exit and re-entry
    wr(0, 1);
    idle(30);
    wr(0, 5);
    idle(30);
    check("R8 sw set", boot_mode, 1);
    wr(0, 0);
    idle(40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule